// File: doc/BRIEF.md
# Serial Interrupt Frame Generator

This block is the peripheral end of a serial interrupt wire. A host and any number of peripherals share one open-drain line with a pull-up. The host opens each frame with a long low start pulse. A fixed train of three-clock slots follows, and a short stop pulse closes the frame. The block watches the line, counts slots, and pulls the line low in the slot that belongs to each interrupt source that is active. The sources are two from the first host channel (IRQ1, IRQ12) and five shared by the second and third channels (SMI, IRQ6, IRQ9, IRQ10, IRQ11).

The length of the host's stop pulse sets the frame mode. In continuous mode only the host starts frames. In quiet mode the block may open a frame itself with a one-clock low pulse when a source's level differs from the level it last reported. The host then stretches that pulse into a full start pulse. If the host has signalled through the clock-run line that the bus clock is about to stop, the block first pulls that line low for a short burst. It starts a frame only after it sees the line held low by someone else.

Top module: `sirq_frame_gen`

## Requirements
- R1: After reset both line drivers are released (`serirq_oe_o` and `clkrun_oe_o` low) and the block is in continuous mode.
- R2: Source bit positions are 0 IRQ1, 1 SMI, 2 IRQ6, 3 IRQ9, 4 IRQ10, 5 IRQ11, 6 IRQ12. They map to slots 1, 2, 6, 9, 10, 11 and 12. In the sample clock of each slot (the first of its three) the block drives low exactly when that slot's source is active. Slot 0 is the first high clock after the start pulse, and slot n's sample clock comes 3n clocks after it.
- R3: After a low sample clock the block drives the line high for exactly the next (recovery) clock and releases it in the turnaround clock. It never drives high at any other time.
- R4: Only a start pulse of 4 to 8 low clocks opens a frame. After a start pulse of any other length the block drives nothing in the slots that follow.
- R5: After the 16th slot, a stop pulse of 2 low clocks selects quiet mode and one of 3 low clocks selects continuous mode. A stop pulse of any other length leaves the mode as it was.
- R6: In quiet mode, with the line idle and the clock-run line held low by another driver, the block pulls the line low for one clock in the clock after a source level comes to differ from the level it last reported. In continuous mode it never starts a frame.
- R7: When every source level equals the level reported in the last frame, the block does not start a frame.
- R8: In quiet mode with a pending change and the clock-run line high, the block drives clock-run low for exactly 2 clocks, once, and starts no frame.
- R9: Once the clock-run line is seen low while the block itself is not driving it, the pending frame start follows in the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 7 | Interrupt source levels, positions as in R2 |
| serirq_i | input | 1 | Sampled level of the shared interrupt line |
| serirq_oe_o | output | 1 | Drive enable for the interrupt line |
| serirq_o | output | 1 | Level driven when enabled (0 pull, 1 recovery) |
| clkrun_i | input | 1 | Sampled level of the clock-run line |
| clkrun_oe_o | output | 1 | Pull the clock-run line low |

## Verification
The bench aims at the edges of the start-pulse window (3 and 9 clocks against 4 and 8). A design with an off-by-one in its counter would fill slots after a bad start or ignore a good one. It checks that recovery comes only after the block's own low sample and that the line is released in turnaround. A slip in the phase counter would put the drive in the wrong slot or leave the line driven when another agent owns it. It checks stop pulses of 2, 3 and 5 clocks, and it checks that a quiet-mode start waits for an actual level change and for the clock-run line. A wrong design would start endless frames, would start frames in continuous mode, or would pulse clock-run more than once.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int SLOTS = 16;
  localparam int SRC_N = 7;

  typedef enum logic [1:0] {
    TRK_IDLE,
    TRK_START,
    TRK_SLOTS,
    TRK_STOP
  } trk_state_e;

  // Place each source level in the slot position that carries it.
  function automatic logic [SLOTS-1:0] src_to_slots(input logic [SRC_N-1:0] s);
    logic [SLOTS-1:0] v;
    v     = '0;
    v[1]  = s[0];
    v[2]  = s[1];
    v[6]  = s[2];
    v[9]  = s[3];
    v[10] = s[4];
    v[11] = s[5];
    v[12] = s[6];
    return v;
  endfunction

  function automatic logic start_len_ok(input int n, input int lo, input int hi);
    return (n >= lo) && (n <= hi);
  endfunction

  // Mode after a stop pulse of the given length (1 = quiet).
  function automatic logic quiet_after_stop(input int n, input logic cur);
    if (n == 2) return 1'b1;
    if (n == 3) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/sirq_frame_tracker.sv
module sirq_frame_tracker
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int START_MIN = 4,
  parameter int START_MAX = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int CNT_W  = $clog2(START_MAX + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  output trk_state_e        state_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [1:0]        phase_o,
  output logic              quiet_o,
  output logic              frame_go_o,
  output logic              stop_end_o
);

  localparam logic [CNT_W-1:0]  CNT_SAT   = '1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  trk_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] slot_q;
  logic [1:0]        phase_q;
  logic              quiet_q;

  // Registers describe the bus clock that the next edge samples.
  assign frame_go_o = (state_q == TRK_START) && line_i &&
                      start_len_ok(int'(cnt_q), START_MIN, START_MAX);
  assign stop_end_o = (state_q == TRK_STOP) && line_i && (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TRK_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
      phase_q <= '0;
      quiet_q <= 1'b0;
    end else begin
      case (state_q)
        TRK_IDLE: if (!line_i) begin
          state_q <= TRK_START;
          cnt_q   <= CNT_W'(1);
        end
        TRK_START: begin
          if (!line_i) begin
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
          end else if (frame_go_o) begin
            state_q <= TRK_SLOTS;
            slot_q  <= '0;
            phase_q <= 2'd1;
          end else begin
            state_q <= TRK_IDLE;
          end
        end
        TRK_SLOTS: begin
          if (phase_q == 2'd2) begin
            phase_q <= 2'd0;
            if (slot_q == SLOT_LAST) begin
              state_q <= TRK_STOP;
              cnt_q   <= '0;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end else begin
            phase_q <= phase_q + 2'd1;
          end
        end
        default: begin
          if (!line_i) begin
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
          end else if (stop_end_o) begin
            state_q <= TRK_IDLE;
            quiet_q <= quiet_after_stop(int'(cnt_q), quiet_q);
          end
        end
      endcase
    end
  end

  assign state_o = state_q;
  assign slot_o  = slot_q;
  assign phase_o = phase_q;
  assign quiet_o = quiet_q;

endmodule

// File: rtl/sirq_slot_driver.sv
module sirq_slot_driver
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_i,
  input  trk_state_e           state_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [1:0]           phase_i,
  input  logic                 quiet_i,
  input  logic                 clk_ok_i,
  input  logic [NUM_SLOTS-1:0] slot_req_i,
  output logic                 oe_o,
  output logic                 val_o,
  output logic                 pending_o,
  output logic                 self_start_o
);

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  logic                 oe_q, val_q;
  logic [NUM_SLOTS-1:0] sent_q;
  logic [SLOT_W-1:0]    nxt_slot;
  logic                 drive_sample, drive_recov, in_slots;

  assign in_slots     = (state_i == TRK_SLOTS);
  assign nxt_slot     = slot_i + 1'b1;
  assign pending_o    = |(slot_req_i ^ sent_q);
  assign self_start_o = (state_i == TRK_IDLE) && quiet_i && pending_o &&
                        line_i && clk_ok_i && !oe_q;
  assign drive_sample = in_slots && (phase_i == 2'd2) &&
                        (slot_i != SLOT_LAST) && slot_req_i[nxt_slot];
  assign drive_recov  = in_slots && (phase_i == 2'd0) && oe_q && !val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      val_q  <= 1'b0;
      sent_q <= '0;
    end else begin
      oe_q  <= self_start_o || drive_sample || drive_recov;
      val_q <= drive_recov;
      if (in_slots && (phase_i == 2'd0))
        sent_q[slot_i] <= oe_q && !val_q;
    end
  end

  assign oe_o  = oe_q;
  assign val_o = val_q;

endmodule

// File: rtl/sirq_clkrun_req.sv
module sirq_clkrun_req #(
  parameter int HOLD = 2,
  localparam int W = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_i,
  input  logic clkrun_i,
  output logic drive_o,
  output logic clk_ok_o
);

  logic [W-1:0] cnt_q;
  logic         done_q;
  logic         fire;

  assign clk_ok_o = !clkrun_i && (cnt_q == '0);
  assign fire     = want_i && clkrun_i && (cnt_q == '0) && !done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (fire)             cnt_q <= W'(HOLD);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (fire)             done_q <= 1'b1;
      else if (clk_ok_o)    done_q <= 1'b0;
    end
  end

  assign drive_o = (cnt_q != '0);

endmodule

// File: rtl/sirq_frame_gen.sv
module sirq_frame_gen
  import sirq_pkg::*;
#(
  parameter int START_MIN   = 4,
  parameter int START_MAX   = 8,
  parameter int CLKRUN_HOLD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_req_i,
  input  logic             serirq_i,
  output logic             serirq_oe_o,
  output logic             serirq_o,
  input  logic             clkrun_i,
  output logic             clkrun_oe_o
);

  localparam int NUM_SLOTS = SLOTS;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  trk_state_e           trk_state;
  logic [SLOT_W-1:0]    trk_slot;
  logic [1:0]           trk_phase;
  logic [NUM_SLOTS-1:0] slot_req;
  logic                 quiet_w, frame_go_w, stop_end_w;
  logic                 pending_w, self_start_w, clk_ok_w;
  logic                 trk_idle_w, trk_sample_w;

  assign slot_req     = src_to_slots(src_req_i);
  assign trk_idle_w   = (trk_state == TRK_IDLE);
  assign trk_sample_w = (trk_state == TRK_SLOTS) && (trk_phase == 2'd0);

  sirq_frame_tracker #(
    .NUM_SLOTS(NUM_SLOTS), .START_MIN(START_MIN), .START_MAX(START_MAX)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .line_i(serirq_i),
    .state_o(trk_state), .slot_o(trk_slot), .phase_o(trk_phase),
    .quiet_o(quiet_w), .frame_go_o(frame_go_w), .stop_end_o(stop_end_w)
  );

  sirq_slot_driver #(.NUM_SLOTS(NUM_SLOTS)) u_drv (
    .clk(clk), .rst_n(rst_n), .line_i(serirq_i),
    .state_i(trk_state), .slot_i(trk_slot), .phase_i(trk_phase),
    .quiet_i(quiet_w), .clk_ok_i(clk_ok_w), .slot_req_i(slot_req),
    .oe_o(serirq_oe_o), .val_o(serirq_o),
    .pending_o(pending_w), .self_start_o(self_start_w)
  );

  sirq_clkrun_req #(.HOLD(CLKRUN_HOLD)) u_ckr (
    .clk(clk), .rst_n(rst_n),
    .want_i(trk_idle_w && quiet_w && pending_w),
    .clkrun_i(clkrun_i), .drive_o(clkrun_oe_o), .clk_ok_o(clk_ok_w)
  );

endmodule

// File: rtl/sirq_frame_chk.sv
module sirq_frame_chk (
  input logic clk,
  input logic rst_n,
  input logic serirq_oe_o,
  input logic serirq_o,
  input logic clkrun_oe_o,
  input logic trk_idle_w,
  input logic trk_sample_w,
  input logic self_start_w,
  input logic quiet_w,
  input logic stop_end_w
);

  // R3
  recovery_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serirq_oe_o && serirq_o) |-> $past(serirq_oe_o && !serirq_o));

  // R3
  release_after_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serirq_oe_o && serirq_o) |=> !serirq_oe_o);

  // R2
  low_only_in_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serirq_oe_o && !serirq_o) |-> (trk_idle_w || trk_sample_w));

  // R6
  self_start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    self_start_w |-> quiet_w);

  // R6
  self_start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    self_start_w |=> !self_start_w);

  // R5
  mode_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(quiet_w) |-> $past(stop_end_w));

  // R8 (default hold of two clocks)
  clkrun_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkrun_oe_o) |=> clkrun_oe_o);

  // R8
  clkrun_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clkrun_oe_o && $past(clkrun_oe_o)) |=> !clkrun_oe_o);

endmodule

bind sirq_frame_gen sirq_frame_chk u_chk (
  .clk(clk), .rst_n(rst_n), .serirq_oe_o(serirq_oe_o), .serirq_o(serirq_o),
  .clkrun_oe_o(clkrun_oe_o), .trk_idle_w(trk_idle_w),
  .trk_sample_w(trk_sample_w), .self_start_w(self_start_w),
  .quiet_w(quiet_w), .stop_end_w(stop_end_w)
);

// File: tb/test_sirq_frame_gen.sv
`timescale 1ns/1ps
module test_sirq_frame_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] src_req = '0;
  logic       host_low = 1'b0;
  logic       ck_host_low = 1'b1;
  logic       serirq_oe, serirq_val, clkrun_oe;
  wire        serirq = ~(host_low | (serirq_oe & ~serirq_val));
  wire        clkrun = ~(ck_host_low | clkrun_oe);
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  sirq_frame_gen i_sirq_frame_gen (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .serirq_i(serirq),
    .serirq_oe_o(serirq_oe), .serirq_o(serirq_val),
    .clkrun_i(clkrun), .clkrun_oe_o(clkrun_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Slot pattern restated from the requirement, one source at a time.
  function automatic logic [15:0] want_slots(input logic [6:0] r);
    logic [15:0] m = '0;
    if (r[0]) m[1] = 1'b1;
    if (r[1]) m[2] = 1'b1;
    if (r[2]) m[6] = 1'b1;
    for (int k = 0; k < 3; k++) if (r[3+k]) m[9+k] = 1'b1;
    if (r[6]) m[12] = 1'b1;
    return m;
  endfunction

  // One bus clock: set host drive after the falling edge, then look.
  task automatic bus(input bit low, output bit line);
    @(negedge clk);
    host_low = low;
    #1;
    line = serirq;
  endtask

  task automatic idle_quiet(input int n, input string req, input string what);
    bit l;
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      bus(0, l);
      if (!l) lows++;
    end
    check(lows == 0, req, what, lows, 0);
  endtask

  task automatic run_frame(input int slen, input int stoplen,
                           input logic [15:0] exp, input string what);
    bit l;
    logic [15:0] seen = '0;
    int bad_rec = 0;
    for (int i = 0; i < slen; i++) bus(1, l);
    for (int n = 0; n < 16; n++) begin
      for (int p = 0; p < 3; p++) begin
        bus(0, l);
        if (p == 0) seen[n] = ~l;
        if (p == 1 && ((serirq_oe && serirq_val) != seen[n])) bad_rec++;
        if (p == 2 && serirq_oe) bad_rec++;
      end
    end
    for (int i = 0; i < stoplen; i++) bus(1, l);
    for (int i = 0; i < 3; i++) bus(0, l);
    check(seen == exp, "R2/R4", what, int'(seen), int'(exp));
    check(bad_rec == 0, "R3", {what, " recovery/turnaround"}, bad_rec, 0);
  endtask

  task automatic t_reset;
    check(!serirq_oe && !clkrun_oe, "R1", "drivers released", int'({serirq_oe, clkrun_oe}), 0);
    src_req = 7'b0000011;
    idle_quiet(8, "R1", "continuous after reset: no start");
  endtask

  task automatic t_frames;
    src_req = 7'b1000001;
    run_frame(4, 3, want_slots(src_req), "start 4 irq1+irq12");
    src_req = 7'b0111110;
    run_frame(8, 2, want_slots(src_req), "start 8 smi/irq6/irq9-11");
    idle_quiet(8, "R7", "quiet, nothing changed");
    run_frame(3, 0, 16'h0000, "R4 start 3 ignored");
    run_frame(9, 0, 16'h0000, "R4 start 9 ignored");
    idle_quiet(4, "R7", "still nothing changed");
  endtask

  task automatic t_self_start;
    bit l;
    src_req = 7'b1111111;
    bus(0, l);
    check(!l, "R6", "self start low after change", l, 0);
    bus(1, l);
    check(!serirq_oe, "R6", "self start one clock", serirq_oe, 0);
    run_frame(3, 2, want_slots(src_req), "R6 frame after self start");
    run_frame(4, 5, want_slots(src_req), "stop 5 frame");
    src_req = 7'b1111110;
    bus(0, l);
    check(!l, "R5", "stop 5 kept quiet mode", l, 0);
    bus(1, l);
    run_frame(3, 3, want_slots(src_req), "frame before continuous");
    src_req = 7'b0000110;
    idle_quiet(8, "R5", "stop 3 gave continuous: no start");
    run_frame(5, 2, want_slots(src_req), "frame back to quiet");
  endtask

  task automatic t_clkrun;
    bit l;
    int ck = 0, lows = 0;
    bus(0, l);
    ck_host_low = 1'b0;
    src_req = 7'b0001110;
    for (int i = 0; i < 8; i++) begin
      bus(0, l);
      if (clkrun_oe) ck++;
      if (!l) lows++;
    end
    check(ck == 2, "R8", "clkrun drive clocks", ck, 2);
    check(lows == 0, "R8", "no start while clock stopping", lows, 0);
    ck_host_low = 1'b1;
    bus(0, l);
    check(!l, "R9", "start after clkrun low", l, 0);
    bus(1, l);
    run_frame(3, 2, want_slots(src_req), "R9 frame after clkrun");
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_frames();
    t_self_start();
    t_clkrun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule